// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Target

This block is a target on an I2C/SMBus-compatible two-wire bus. It gives a host access to a bank of 16-bit registers through an 8-bit pointer that the block keeps. A fast system clock oversamples SCL and SDA. Start, repeated-start and stop conditions are found from the sampled lines. The block answers one fixed 7-bit address and pulls SDA low only through an open-drain enable.

A write transfer always carries the pointer as its first byte. It may then carry a word: high byte first, then low byte. A read transfer returns data from the register that the pointer selects. The host can read one byte, one word, or any number of words. During a read, the pointer moves forward once for each word. Because the pointer is kept between transfers, the host can read again without setting it again. The register bank lives outside the block. It is reached through a read port that follows the pointer and through a one-cycle write strobe.

The controller is a single state machine with these states:
- `S_IDLE`: waits for a start.
- `S_ADDR`: shifts in the address byte.
- `S_ADDR_ACK`: acknowledges the address.
- `S_PTR`: receives the pointer byte.
- `S_PTR_ACK`: acknowledges the pointer byte.
- `S_WDATA`: receives a data byte.
- `S_WDATA_ACK`: acknowledges a data byte.
- `S_TX`: sends a byte.
- `S_TX_ACK`: samples the host's acknowledge.
- `S_SKIP`: stays silent until the next start or stop.

Transitions:
- A start moves any state to `S_ADDR`.
- A stop moves any state to `S_IDLE`.
- `S_ADDR` goes to `S_ADDR_ACK` when the address matches, and to `S_SKIP` when it does not.
- `S_ADDR_ACK` goes to `S_TX` for a read, or to `S_PTR` for a write.
- `S_PTR` goes to `S_PTR_ACK`, then to `S_WDATA`.
- `S_WDATA` and `S_WDATA_ACK` alternate for as long as the host keeps sending bytes.
- `S_TX` goes to `S_TX_ACK`. From there the block returns to `S_TX` on an acknowledge, or goes to `S_SKIP` on a not-acknowledge.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), `reg_we` is low and the pointer (`reg_addr`) is 0. A read issued with no pointer byte then returns register 0.
- R2: SDA falling while SCL is high starts a transfer, and a later start restarts the address phase. SDA rising while SCL is high ends the transfer, and afterwards the block leaves SDA released.
- R3: A start is followed by an address byte: the 7-bit address, then the direction bit (1 = read). When the address equals `TARGET_ADDR`, the block holds SDA low for the whole high phase of the ninth clock. Any other address gets no acknowledge, and nothing more is driven or written until the next start or stop.
- R4: A write that ends after the pointer byte loads the pointer and writes no register.
- R5: In a write, the first data byte is the high byte and the second is the low byte. One `reg_we` pulse stores the word at the pointer, and it comes only after the second data byte has been acknowledged. A transfer that stops or restarts after only one data byte writes nothing.
- R6: Read data goes out most significant bit first, with the high byte of the word first. A read of one byte that the host then refuses returns the high byte and leaves the pointer unchanged.
- R7: In a read, the pointer increases by one, modulo 256, each time the low byte of a word is sent. A burst of N words therefore returns N consecutive registers, and a later read without a pointer byte continues from where the burst ended.
- R8: After the host refuses a byte it has read, the block releases SDA and drives nothing until the next start or stop.
- R9: `sda_oe` changes only while the synchronised SCL is low, and `reg_we` is never high for two cycles in a row.
- R10: Setting the pointer, then a repeated start and a read, returns data from the newly selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| reg_addr | output | PTR_W | Current pointer; selects the register on both ports |
| reg_rdata | input | 16 | Contents of the register at `reg_addr` |
| reg_wdata | output | 16 | Word to be written |
| reg_we | output | 1 | One-cycle write strobe for `reg_addr` |

## Verification
The hardest condition to reach from the ports is the pointer wrapping from 255 to 0 in the middle of a burst. Close behind it is a half-finished write that a repeated start cuts short. The stimulus table sets the pointer to 255 and reads two words, which forces the wrap. A directed sequence sends one data byte and then issues a repeated start followed by a read, which proves that no write took place and that the pointer still moved. Register contents are compared against a model that the bench keeps from the requirements alone. After each refused read byte, extra clock pulses are sent to confirm that SDA stays released.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_TX_ACK,
        S_SKIP
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b1;
                end else if (g == 0) begin
                    chain[g] <= line_in;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign line_out = chain[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Conditions count only while SCL stays high across both samples.
    assign start_evt = scl_s && scl_q && sda_q && !sda_s;
    assign stop_evt  = scl_s && scl_q && !sda_q && sda_s;
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h4C,
    parameter int         PTR_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               start_evt,
    input  logic               stop_evt,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic [WORD_W-1:0]  reg_rdata,
    output logic               sda_oe,
    output logic [PTR_W-1:0]   reg_addr,
    output logic [WORD_W-1:0]  reg_wdata,
    output logic               reg_we,
    output tgt_state_e         state
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e         nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  txsh;
    logic [BYTE_W-1:0]  lo_hold;
    logic [BYTE_W-1:0]  hi_hold;
    logic [PTR_W-1:0]   ptr;
    logic               rw_read;
    logic               lo_phase;
    logic               host_ack;
    logic               rx_done;
    logic               tx_done;
    logic               addr_hit;

    assign rx_done  = (bit_cnt == RX_LAST);
    assign tx_done  = (bit_cnt == TX_LAST);
    assign addr_hit = (shreg[BYTE_W-1:1] == TARGET_ADDR);
    assign reg_addr = ptr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        if (start_evt) begin
            nxt = S_ADDR;
        end else if (stop_evt) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_ADDR:      if (scl_fall && rx_done) nxt = addr_hit ? S_ADDR_ACK : S_SKIP;
                S_ADDR_ACK:  if (scl_fall) nxt = rw_read ? S_TX : S_PTR;
                S_PTR:       if (scl_fall && rx_done) nxt = S_PTR_ACK;
                S_PTR_ACK:   if (scl_fall) nxt = S_WDATA;
                S_WDATA:     if (scl_fall && rx_done) nxt = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) nxt = S_WDATA;
                S_TX:        if (scl_fall && tx_done) nxt = S_TX_ACK;
                S_TX_ACK:    if (scl_fall) nxt = host_ack ? S_TX : S_SKIP;
                S_SKIP:      nxt = S_SKIP;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            txsh      <= '0;
            lo_hold   <= '0;
            hi_hold   <= '0;
            ptr       <= '0;
            rw_read   <= 1'b0;
            lo_phase  <= 1'b0;
            host_ack  <= 1'b0;
            sda_oe    <= 1'b0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (start_evt || stop_evt) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_PTR, S_WDATA: begin
                        if (scl_rise && !rx_done) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && rx_done) begin
                            bit_cnt <= '0;
                            sda_oe  <= (state != S_ADDR) || addr_hit;
                            if (state == S_ADDR) rw_read <= shreg[0];
                            if (state == S_PTR) begin
                                ptr      <= shreg[PTR_W-1:0];
                                lo_phase <= 1'b0;
                            end
                            if (state == S_WDATA && !lo_phase) hi_hold <= shreg;
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_read) begin
                                txsh     <= reg_rdata[WORD_W-1:BYTE_W];
                                lo_hold  <= reg_rdata[BYTE_W-1:0];
                                sda_oe   <= ~reg_rdata[WORD_W-1];
                                lo_phase <= 1'b0;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    S_PTR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                        end
                    end
                    S_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe   <= 1'b0;
                            lo_phase <= ~lo_phase;
                            if (lo_phase) begin
                                reg_we    <= 1'b1;
                                reg_wdata <= {hi_hold, shreg};
                            end
                        end
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            if (tx_done) begin
                                sda_oe <= 1'b0;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                txsh    <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    S_TX_ACK: begin
                        if (scl_rise) host_ack <= ~sda_s;
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (!host_ack) begin
                                sda_oe <= 1'b0;
                            end else if (!lo_phase) begin
                                txsh     <= lo_hold;
                                sda_oe   <= ~lo_hold[BYTE_W-1];
                                ptr      <= ptr + 1'b1;
                                lo_phase <= 1'b1;
                            end else begin
                                txsh     <= reg_rdata[WORD_W-1:BYTE_W];
                                lo_hold  <= reg_rdata[BYTE_W-1:0];
                                sda_oe   <= ~reg_rdata[WORD_W-1];
                                lo_phase <= 1'b0;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h4C,
    parameter int         SYNC_STAGES = 2,
    parameter int         PTR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    input  logic [15:0]       reg_rdata,
    output logic [15:0]       reg_wdata,
    output logic              reg_we
);

    logic       scl_s;
    logic       sda_s;
    logic       start_evt;
    logic       stop_evt;
    logic       scl_rise;
    logic       scl_fall;
    tgt_state_e fsm_state;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (scl_in),
        .line_out (scl_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (sda_in),
        .line_out (sda_s)
    );

    i2c_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_tgt_fsm #(.TARGET_ADDR(TARGET_ADDR), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .state     (fsm_state)
    );

endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       reg_we,
    input logic       start_evt,
    input logic       stop_evt,
    input tgt_state_e fsm_state
);

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R9

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R9

    AST_WE_AFTER_SECOND_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(fsm_state) == S_WDATA_ACK)); // R5

    AST_SILENT_WHEN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_IDLE || fsm_state == S_SKIP) |-> !sda_oe); // R8

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (fsm_state == S_ADDR)); // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (fsm_state == S_IDLE)); // R2

endmodule

bind i2c_ptr_target i2c_ptr_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .fsm_state (fsm_state)
);

// File: tb/i2c_ptr_target_bench.sv
module i2c_ptr_target_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam int         WATCHDOG   = 150000;
    localparam logic [6:0] DEV_ADDR   = 7'h4C;

    localparam logic [3:0] OP_WR   = 4'd0;
    localparam logic [3:0] OP_PTR  = 4'd1;
    localparam logic [3:0] OP_RDS  = 4'd2;
    localparam logic [3:0] OP_RDN  = 4'd3;
    localparam logic [3:0] OP_RBS  = 4'd4;
    localparam logic [3:0] OP_RBN  = 4'd5;
    localparam logic [3:0] OP_BAD  = 4'd6;
    localparam logic [3:0] OP_HALF = 4'd7;

    // {op, word count, pointer, data}
    localparam int NVEC = 13;
    localparam logic [31:0] VEC [NVEC] = '{
        {OP_RDN,  4'd1, 8'h00, 16'h0000},
        {OP_WR,   4'd0, 8'h03, 16'hBEEF},
        {OP_RDS,  4'd1, 8'h03, 16'h0000},
        {OP_WR,   4'd0, 8'h04, 16'h1234},
        {OP_RDN,  4'd2, 8'h00, 16'h0000},
        {OP_PTR,  4'd0, 8'h10, 16'h0000},
        {OP_RBN,  4'd0, 8'h00, 16'h0000},
        {OP_RBS,  4'd0, 8'h04, 16'h0000},
        {OP_RDS,  4'd2, 8'hFF, 16'h0000},
        {OP_BAD,  4'd0, 8'h20, 16'h5555},
        {OP_HALF, 4'd0, 8'h21, 16'hAA00},
        {OP_RDS,  4'd3, 8'h1F, 16'h0000},
        {OP_RDN,  4'd1, 8'h00, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [7:0]  reg_addr;
    logic [15:0] reg_rdata;
    logic [15:0] reg_wdata;
    logic        reg_we;

    logic [15:0] bank  [256];
    logic [15:0] model [256];
    logic [7:0]  mptr;
    int          checks = 0;
    int          fails = 0;
    int          we_count = 0;
    int          we_double = 0;
    logic        we_prev = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = sda_h & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_ptr_target #(.TARGET_ADDR(DEV_ADDR)) u_i2c_ptr_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_h),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we)
    );

    always @(posedge clk) begin
        if (reg_we) bank[reg_addr] <= reg_wdata;
    end

    always @(negedge clk) begin
        if (reg_we) we_count++;
        if (reg_we && we_prev) we_double++;
        we_prev = reg_we;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wq(Q);
        scl_h = 1'b1; wq(Q);
        sda_h = 1'b0; wq(Q);
        scl_h = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq(Q);
        scl_h = 1'b1; wq(Q);
        sda_h = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a0, a1;
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wq(Q);
            scl_h = 1'b1; wq(Q);
            scl_h = 1'b0; wq(Q);
        end
        sda_h = 1'b1; wq(Q);
        scl_h = 1'b1; wq(2);
        a0 = ~sda_line; wq(Q-2);
        a1 = ~sda_line;
        scl_h = 1'b0; wq(Q);
        ack = a0 & a1;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; wq(Q);
            scl_h = 1'b1; wq(Q/2);
            b[i] = sda_line; wq(Q/2);
            scl_h = 1'b0; wq(Q);
        end
        sda_h = give_ack ? 1'b0 : 1'b1; wq(Q);
        scl_h = 1'b1; wq(Q);
        scl_h = 1'b0; wq(Q);
        sda_h = 1'b1;
    endtask

    task automatic read_words(input int n, input string req);
        logic [7:0] hi, lo;
        for (int k = 0; k < n; k++) begin
            recv_byte(1'b1, hi);
            recv_byte(k < n-1, lo);
            chk({hi, lo} == model[mptr], req, {16'h0, hi, lo}, {16'h0, model[mptr]});
            mptr = mptr + 8'd1;
        end
    endtask

    // R8: after a refused byte the line must stay released for further clocks.
    task automatic post_nack();
        bit low_seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            sda_h = 1'b1; wq(Q);
            scl_h = 1'b1; wq(Q/2);
            if (!sda_line) low_seen = 1'b1;
            wq(Q/2);
            scl_h = 1'b0; wq(Q);
        end
        chk(!low_seen, "R8", {31'h0, low_seen}, 32'h0);
    endtask

    task automatic end_idle();
        bus_stop();
        wq(4);
        chk(sda_oe == 1'b0, "R2", {31'h0, sda_oe}, 32'h0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit         ack;
        int         wc;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) begin
            bank[i]  = {8'(i) ^ 8'h3C, ~8'(i)};
            model[i] = {8'(i) ^ 8'h3C, ~8'(i)};
        end
        mptr = 8'h00;
        wq(5);
        chk(sda_oe == 1'b0, "R1", {31'h0, sda_oe}, 32'h0);
        chk(reg_we == 1'b0, "R1", {31'h0, reg_we}, 32'h0);
        chk(reg_addr == 8'h00, "R1", {24'h0, reg_addr}, 32'h0);
        rst_n = 1'b1;
        wq(10);

        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  op;
            logic [3:0]  n;
            logic [7:0]  p;
            logic [15:0] d;
            {op, n, p, d} = VEC[v];
            bus_start();
            wc = we_count;
            case (op)
                OP_WR: begin
                    send_byte({DEV_ADDR, 1'b0}, ack); chk(ack, "R3", {31'h0, ack}, 32'h1);
                    send_byte(p, ack);                chk(ack, "R3", {31'h0, ack}, 32'h1);
                    send_byte(d[15:8], ack);
                    chk(we_count == wc, "R5", we_count, wc);
                    send_byte(d[7:0], ack);
                    wq(4);
                    chk(we_count == wc + 1, "R5", we_count, wc + 1);
                    model[p] = d;
                    mptr = p;
                end
                OP_PTR: begin
                    send_byte({DEV_ADDR, 1'b0}, ack);
                    send_byte(p, ack);
                    chk(ack && we_count == wc, "R4", we_count, wc);
                    mptr = p;
                end
                OP_RDS: begin
                    send_byte({DEV_ADDR, 1'b0}, ack);
                    send_byte(p, ack);
                    bus_start();
                    send_byte({DEV_ADDR, 1'b1}, ack); chk(ack, "R3", {31'h0, ack}, 32'h1);
                    mptr = p;
                    read_words(int'(n), (n > 1) ? "R7" : "R10");
                    post_nack();
                end
                OP_RDN: begin
                    send_byte({DEV_ADDR, 1'b1}, ack); chk(ack, "R3", {31'h0, ack}, 32'h1);
                    read_words(int'(n), (v == 0) ? "R1" : "R7");
                    post_nack();
                end
                OP_RBS, OP_RBN: begin
                    if (op == OP_RBS) begin
                        send_byte({DEV_ADDR, 1'b0}, ack);
                        send_byte(p, ack);
                        bus_start();
                        mptr = p;
                    end
                    send_byte({DEV_ADDR, 1'b1}, ack);
                    recv_byte(1'b0, b);
                    chk(b == model[mptr][15:8], "R6", {24'h0, b}, {24'h0, model[mptr][15:8]});
                    post_nack();
                end
                OP_BAD: begin
                    send_byte({DEV_ADDR ^ 7'h01, 1'b0}, ack);
                    chk(!ack, "R3", {31'h0, ack}, 32'h0);
                    send_byte(p, ack);       chk(!ack, "R3", {31'h0, ack}, 32'h0);
                    send_byte(d[15:8], ack);
                    send_byte(d[7:0], ack);
                    chk(we_count == wc, "R3", we_count, wc);
                end
                OP_HALF: begin
                    send_byte({DEV_ADDR, 1'b0}, ack);
                    send_byte(p, ack);
                    send_byte(d[15:8], ack);
                    mptr = p;
                end
                default: ;
            endcase
            end_idle();
            if (op == OP_HALF) chk(we_count == wc, "R5", we_count, wc);
        end

        // R5/R10: a lone data byte cut off by a repeated start writes nothing.
        bus_start();
        wc = we_count;
        send_byte({DEV_ADDR, 1'b0}, ack);
        send_byte(8'h30, ack);
        send_byte(8'h77, ack);
        bus_start();
        send_byte({DEV_ADDR, 1'b1}, ack);
        mptr = 8'h30;
        read_words(1, "R10");
        end_idle();
        chk(we_count == wc, "R5", we_count, wc);

        begin
            int mism = 0;
            for (int i = 0; i < 256; i++) if (bank[i] !== model[i]) mism++;
            chk(mism == 0, "R4", mism, 0);
        end
        chk(we_double == 0, "R9", we_double, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule